// File: doc/BRIEF.md
# Control Endpoint Status Register

This block holds the control and status bits of a device-side USB control endpoint. A CPU reaches it through a plain register bus: one write port and one read port. The packet engine reports its events on single-cycle inputs: a data packet arrived, a queued packet went out, a STALL handshake was sent, a control transfer ended early, and the status stage began. Each event updates the same bits that the CPU reads and writes.

Every bit has its own rule. Some are set by the CPU and cleared by the engine. Some are set by the engine and cleared by the CPU through a separate write-one service bit. The block also produces a one-cycle FIFO flush strobe and a one-cycle interrupt pulse. The flush strobe fires on a CPU flush request or when a control transfer ends early, and it clears both packet-ready flags.

Write bit positions: 0 receive ready, 1 transmit ready, 2 stall sent, 3 data end, 4 setup end, 5 send stall, 6 service-receive, 7 service-setup-end, 8 flush. Read bits 0 to 5 return the stored flags. Bit 6 and every bit above it read as zero.

Top module: `cep_status_reg`

## Requirements
- R1: Receive ready (bit 0) sets on the packet-received event, and that event raises an interrupt. A write with bit 6 = 1 clears receive ready.
- R2: Transmit ready (bit 1) sets on a write with bit 1 = 1 and clears on the packet-sent event. The packet-sent event raises an interrupt only if transmit ready was set. A CPU set in the same cycle as packet-sent leaves the bit set.
- R3: Stall sent (bit 2) sets on the stall-sent event. Any write with bit 2 = 0 clears it. A write with bit 2 = 1 leaves it unchanged.
- R4: Data end (bit 3) sets on a write with bit 3 = 1 and clears on the status-stage event. A write with bit 3 = 0 does not clear it. A CPU set in the same cycle as status-stage leaves it set.
- R5: Setup end (bit 4) sets on the early-end event. That event also raises an interrupt, pulses the flush output and clears both packet-ready flags. A write with bit 7 = 1 clears setup end.
- R6: Send stall (bit 5) sets on a write with bit 5 = 1 and clears on the stall-sent event. A write with bit 5 = 0 does not clear it.
- R7: A write with bit 8 = 1 pulses the flush output and clears transmit ready and receive ready. The flush wins over a transmit-ready set carried in the same write.
- R8: Read bits 6 and above are always zero, including just after a write that has bits 6 and 7 set.
- R9: When an engine set event and a CPU clear reach the same bit in one cycle, the set wins. This covers receive ready (against service or flush), setup end and stall sent.
- R10: After reset the register reads zero and both outputs are low. The interrupt and flush outputs are registered. Each is high for exactly the one cycle after its cause, and several causes in the same cycle give a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 9 | Write data, bit positions as above |
| rdData | output | DATA_W (16) | Read data, flags in bits 5:0 |
| evRxPkt | input | 1 | Engine: data packet received |
| evTxDone | input | 1 | Engine: queued packet transmitted |
| evStallSent | input | 1 | Engine: STALL handshake sent |
| evSetupEnd | input | 1 | Engine: control transfer ended early |
| evStatusStage | input | 1 | Engine: status stage started |
| irq | output | 1 | One-cycle interrupt pulse |
| fifoFlush | output | 1 | One-cycle FIFO flush strobe |

## Verification
Every flag is read combinationally from its own register. A wrong next-state rule therefore shows up on rdData in the cycle right after the offending write or event. The interrupt and flush pulses trail their cause by exactly one edge, so a missing, doubled or stretched pulse is visible within two cycles. Most of the stimulus targets same-cycle collisions between engine events and CPU writes, because a priority mistake there leaves a flag with the wrong value, and that wrong value persists on the read port.

// File: rtl/cep_pkg.sv
package cep_pkg;
  localparam int CSR_W   = 9;
  localparam int FLAG_W  = 6;
  localparam int B_RX    = 0;
  localparam int B_TX    = 1;
  localparam int B_STALL = 2;
  localparam int B_DE    = 3;
  localparam int B_SU    = 4;
  localparam int B_SS    = 5;
  localparam int B_SVCRX = 6;
  localparam int B_SVCSU = 7;
  localparam int B_FLUSH = 8;

  typedef struct packed {
    logic setRx, clrRx;
    logic setTx, clrTx;
    logic setStall, clrStall;
    logic setDe, clrDe;
    logic setSu, clrSu;
    logic setSs, clrSs;
    logic flush;
    logic irq;
  } cepStrobes_t;
endpackage

// File: rtl/cep_ctrl.sv
module cep_ctrl
  import cep_pkg::*;
(
  input  logic               wrEn,
  input  logic [CSR_W-1:0]   wrData,
  input  logic               evRxPkt,
  input  logic               evTxDone,
  input  logic               evStallSent,
  input  logic               evSetupEnd,
  input  logic               evStatusStage,
  input  logic               txRdyNow,
  output cepStrobes_t        st
);
  always_comb begin
    st          = '0;
    st.setRx    = evRxPkt;
    st.clrRx    = wrEn & wrData[B_SVCRX];
    st.setTx    = wrEn & wrData[B_TX];
    st.clrTx    = evTxDone;
    st.setStall = evStallSent;
    st.clrStall = wrEn & ~wrData[B_STALL];
    st.setDe    = wrEn & wrData[B_DE];
    st.clrDe    = evStatusStage;
    st.setSu    = evSetupEnd;
    st.clrSu    = wrEn & wrData[B_SVCSU];
    st.setSs    = wrEn & wrData[B_SS];
    st.clrSs    = evStallSent;
    st.flush    = (wrEn & wrData[B_FLUSH]) | evSetupEnd;
    // R1 R2 R5: interrupt causes; tx done counts only if a packet was queued
    st.irq      = evRxPkt | evSetupEnd | (evTxDone & txRdyNow);
  end
endmodule

// File: rtl/cep_regs.sv
module cep_regs
  import cep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cepStrobes_t       st,
  output logic [FLAG_W-1:0] flags,
  output logic              irqQ,
  output logic              flushQ
);
  logic rxRdy, txRdy, stallSent, dataEnd, setupEnd, sendStall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxRdy     <= 1'b0;
      txRdy     <= 1'b0;
      stallSent <= 1'b0;
      dataEnd   <= 1'b0;
      setupEnd  <= 1'b0;
      sendStall <= 1'b0;
      irqQ      <= 1'b0;
      flushQ    <= 1'b0;
    end else begin
      rxRdy     <= st.setRx | (rxRdy & ~st.clrRx & ~st.flush);
      txRdy     <= ~st.flush & (st.setTx | (txRdy & ~st.clrTx));
      stallSent <= st.setStall | (stallSent & ~st.clrStall);
      dataEnd   <= st.setDe | (dataEnd & ~st.clrDe);
      setupEnd  <= st.setSu | (setupEnd & ~st.clrSu);
      sendStall <= (sendStall | st.setSs) & ~st.clrSs;
      irqQ      <= st.irq;
      flushQ    <= st.flush;
    end
  end

  always_comb begin
    flags          = '0;
    flags[B_RX]    = rxRdy;
    flags[B_TX]    = txRdy;
    flags[B_STALL] = stallSent;
    flags[B_DE]    = dataEnd;
    flags[B_SU]    = setupEnd;
    flags[B_SS]    = sendStall;
  end

  AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    st.setRx |=> rxRdy); // R9
  AST_TX_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrTx && !st.setTx) |=> !txRdy); // R2
  AST_STALL_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    st.clrSs |=> (!sendStall && stallSent)); // R6
  AST_FLUSH_CLEARS_TX: assert property (@(posedge clk) disable iff (!rstN)
    flushQ |-> !txRdy); // R7
  AST_SETUP_END_ACTIONS: assert property (@(posedge clk) disable iff (!rstN)
    st.setSu |=> (setupEnd && irqQ && flushQ)); // R5
  AST_DATA_END_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrDe && !st.setDe) |=> !dataEnd); // R4
endmodule

// File: rtl/cep_status_reg.sv
module cep_status_reg
  import cep_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [CSR_W-1:0]       wrData,
  output logic [DATA_W-1:0]      rdData,
  input  logic                   evRxPkt,
  input  logic                   evTxDone,
  input  logic                   evStallSent,
  input  logic                   evSetupEnd,
  input  logic                   evStatusStage,
  output logic                   irq,
  output logic                   fifoFlush
);
  localparam int PAD_W = DATA_W - FLAG_W;

  cepStrobes_t        st;
  logic [FLAG_W-1:0]  flags;

  cep_ctrl u_ctrl (
    .wrEn          (wrEn),
    .wrData        (wrData),
    .evRxPkt       (evRxPkt),
    .evTxDone      (evTxDone),
    .evStallSent   (evStallSent),
    .evSetupEnd    (evSetupEnd),
    .evStatusStage (evStatusStage),
    .txRdyNow      (flags[B_TX]),
    .st            (st)
  );

  cep_regs u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .flags  (flags),
    .irqQ   (irq),
    .flushQ (fifoFlush)
  );

  // R8: service and flush bits are strobes and never read back
  assign rdData = {{PAD_W{1'b0}}, flags};

  initial begin
    AST_BUS_WIDE_ENOUGH: assert (DATA_W >= CSR_W); // R8
  end
endmodule

// File: tb/cep_status_reg_tb.sv
module cep_status_reg_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [8:0] wrData = '0;
  logic [15:0] rdData;
  logic evRxPkt = 0, evTxDone = 0, evStallSent = 0, evSetupEnd = 0, evStatusStage = 0;
  logic irq, fifoFlush;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cep_status_reg u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .evRxPkt(evRxPkt), .evTxDone(evTxDone), .evStallSent(evStallSent),
    .evSetupEnd(evSetupEnd), .evStatusStage(evStatusStage),
    .irq(irq), .fifoFlush(fifoFlush)
  );

  // {wr, wdata[8:0], ev{status,setupEnd,stallSent,txDone,rxPkt}, expRd[8:0], expIrq, expFlush}
  localparam int NV = 28;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 9'h000, 5'b00001, 9'h001, 1'b1, 1'b0}, // R1 packet received
    {1'b1, 9'h040, 5'b00000, 9'h000, 1'b0, 1'b0}, // R1 service receive
    {1'b1, 9'h002, 5'b00000, 9'h002, 1'b0, 1'b0}, // R2 cpu sets tx ready
    {1'b0, 9'h000, 5'b00010, 9'h000, 1'b1, 1'b0}, // R2 packet sent
    {1'b0, 9'h000, 5'b00010, 9'h000, 1'b0, 1'b0}, // R2 sent with nothing queued
    {1'b1, 9'h020, 5'b00000, 9'h020, 1'b0, 1'b0}, // R6 send stall
    {1'b0, 9'h000, 5'b00100, 9'h004, 1'b0, 1'b0}, // R6 stall goes out
    {1'b1, 9'h000, 5'b00000, 9'h000, 1'b0, 1'b0}, // R3 write 0 clears stall sent
    {1'b1, 9'h008, 5'b00000, 9'h008, 1'b0, 1'b0}, // R4 data end set
    {1'b0, 9'h000, 5'b10000, 9'h000, 1'b0, 1'b0}, // R4 status stage clears
    {1'b1, 9'h002, 5'b00001, 9'h003, 1'b1, 1'b0}, // R2 set with rx event
    {1'b0, 9'h000, 5'b01000, 9'h010, 1'b1, 1'b1}, // R5 early end
    {1'b1, 9'h080, 5'b00000, 9'h000, 1'b0, 1'b0}, // R5 service setup end
    {1'b0, 9'h000, 5'b00001, 9'h001, 1'b1, 1'b0}, // R1 receive again
    {1'b1, 9'h040, 5'b00001, 9'h001, 1'b1, 1'b0}, // R9 set beats service
    {1'b1, 9'h100, 5'b00000, 9'h000, 1'b0, 1'b1}, // R7 flush clears rx
    {1'b1, 9'h0C2, 5'b00000, 9'h002, 1'b0, 1'b0}, // R8 strobes read zero
    {1'b1, 9'h102, 5'b00000, 9'h000, 1'b0, 1'b1}, // R7 flush beats tx set
    {1'b1, 9'h080, 5'b01000, 9'h010, 1'b1, 1'b1}, // R9 early end beats service
    {1'b1, 9'h080, 5'b00000, 9'h000, 1'b0, 1'b0}, // R5 cleared
    {1'b1, 9'h008, 5'b00000, 9'h008, 1'b0, 1'b0}, // R4 set
    {1'b1, 9'h000, 5'b00000, 9'h008, 1'b0, 1'b0}, // R4 write 0 keeps
    {1'b1, 9'h008, 5'b10000, 9'h008, 1'b0, 1'b0}, // R4 cpu set beats status
    {1'b0, 9'h000, 5'b10000, 9'h000, 1'b0, 1'b0}, // R4 status clears
    {1'b1, 9'h002, 5'b00010, 9'h002, 1'b0, 1'b0}, // R2 set beats sent, no irq
    {1'b1, 9'h020, 5'b00100, 9'h006, 1'b0, 1'b0}, // R9 stall set beats write 0
    {1'b1, 9'h004, 5'b00000, 9'h006, 1'b0, 1'b0}, // R3 write 1 keeps
    {1'b0, 9'h000, 5'b01000, 9'h014, 1'b1, 1'b1}  // R5 early end drops tx
  };
  string vecReq [NV] = '{"R1","R1","R2","R2","R2","R6","R6","R3","R4","R4",
                         "R2","R5","R5","R1","R9","R7","R8","R7","R9","R5",
                         "R4","R4","R4","R4","R2","R9","R3","R5"};

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic idle();
    wrEn = 0; wrData = '0;
    {evStatusStage, evSetupEnd, evStallSent, evTxDone, evRxPkt} = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "reset rdData", rdData, 16'h0000);
    check("R10", "reset irq", {15'b0, irq}, 16'h0);
    check("R10", "reset flush", {15'b0, fifoFlush}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      wrEn   = VEC[i][25];
      wrData = VEC[i][24:16];
      {evStatusStage, evSetupEnd, evStallSent, evTxDone, evRxPkt} = VEC[i][15:11];
      @(negedge clk);
      idle();
      check(vecReq[i], $sformatf("vec %0d rdData", i), rdData, {7'b0, VEC[i][10:2]});
      check(vecReq[i], $sformatf("vec %0d irq", i), {15'b0, irq}, {15'b0, VEC[i][1]});
      check(vecReq[i], $sformatf("vec %0d flush", i), {15'b0, fifoFlush}, {15'b0, VEC[i][0]});
    end
    // R10 pulses last one cycle
    @(negedge clk);
    check("R10", "irq after one cycle", {15'b0, irq}, 16'h0);
    check("R10", "flush after one cycle", {15'b0, fifoFlush}, 16'h0);
    check("R10", "state held", rdData, 16'h0014);
    // R10 two causes in one cycle give one pulse
    evRxPkt = 1; evSetupEnd = 1;
    @(negedge clk);
    idle();
    check("R10", "joint irq", {15'b0, irq}, 16'h1);
    @(negedge clk);
    check("R10", "joint irq single", {15'b0, irq}, 16'h0);
    // R10 reset mid-run clears everything
    wrEn = 1; wrData = 9'h02A;
    @(negedge clk);
    idle();
    rstN = 0;
    @(negedge clk);
    check("R10", "reset clears", rdData, 16'h0000);
    rstN = 1;
    @(negedge clk);
    check("R10", "after reset", rdData, 16'h0000);
    finishRun();
  end
endmodule